// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of a processor that uses overlapping register windows. Thirty-two architectural registers are visible at any moment: eight globals that stay the same in every window, plus twenty-four registers taken from a circular stack of windows. A current-window pointer selects the window. Each window owns eight private locals. It shares eight registers with the window on each side, and these shared groups pass call arguments and return values without any copying.

Two combinational read ports and one clocked write port each take a 5-bit architectural index, which the block maps to a physical register through the current window. A save strobe moves to the callee's window and a restore strobe moves back. An occupancy count tracks how many windows hold live frames. When a save would exhaust the stack, or a restore would leave it with no frame, the block raises a one-cycle flag and leaves the pointer where it was. The surrounding pipeline then decides how to handle the condition.

Top module: `wreg_file`

## Requirements
- R1: Index 0 always reads as zero on both ports, and a write to index 0 has no effect.
- R2: Indices 1 to 7 select global registers that hold the same storage whatever the window pointer is.
- R3: Indices 16 to 23 select locals private to the current window; a save makes them refer to a different, separate set, and a restore brings the earlier set back.
- R4: After a save, indices 24 to 31 (incoming) of the new window read what indices 8 to 15 (outgoing) of the previous window held, at the same offset.
- R5: After a restore, indices 8 to 15 of the restored window read what the callee wrote to indices 24 to 31, at the same offset.
- R6: After reset the pointer is 0 and one window is in use; an accepted save sets the pointer to (p-1) mod NWIN, and an accepted restore sets it to (p+1) mod NWIN.
- R7: A lone save while NWIN-1 windows are in use raises the overflow flag in that same cycle and leaves the pointer and occupancy unchanged.
- R8: A lone restore while one window is in use raises the underflow flag in that same cycle and leaves the pointer and occupancy unchanged.
- R9: Reads are combinational. Reading the register being written in that cycle returns the old value, and the new value appears after the rising edge.
- R10: A write in the same cycle as a save or restore is mapped through the window that was current before the move.
- R11: Save and restore asserted together cancel: the pointer does not move and neither flag is raised.
- R12: The two read ports decode their indices independently, and each can read any register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| save_i | input | 1 | Move to the callee window |
| restore_i | input | 1 | Move back to the caller window |
| we_i | input | 1 | Write enable |
| waddr_i | input | 5 | Architectural write index |
| wdata_i | input | DW | Write data |
| raddr_a_i | input | 5 | Architectural index, read port A |
| raddr_b_i | input | 5 | Architectural index, read port B |
| rdata_a_o | output | DW | Read data, port A |
| rdata_b_o | output | DW | Read data, port B |
| cur_win_o | output | clog2(NWIN) | Current window pointer |
| ovf_o | output | 1 | Window overflow, same cycle as the rejected save |
| unf_o | output | 1 | Window underflow, same cycle as the rejected restore |

## Verification
A register write and a window move can land in the same cycle. In that case the write must use the window in place before the edge and not the one after it. The bench forces this by writing an outgoing register in the save cycle and an incoming register in the restore cycle. It then reads the shared group from the other side of the move. The behavioural model applies the write before it updates its own pointer, so any write that follows the new window shows up as a data mismatch on the next read.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

   localparam int GRP_SIZE  = 8;
   localparam int ARCH_REGS = 32;
   localparam int AIW       = $clog2(ARCH_REGS);

   typedef logic [AIW-1:0] arch_idx_t;

   // decode of the top two index bits; the offset bits below stay as-is
   typedef enum logic [1:0] {
      GRP_GLOBAL = 2'b00,
      GRP_OUT    = 2'b01,
      GRP_LOCAL  = 2'b10,
      GRP_IN     = 2'b11
   } grp_t;

   typedef enum logic [2:0] {
      MV_NONE,
      MV_SAVE,
      MV_RESTORE,
      MV_OVF,
      MV_UNF
   } move_t;

   function automatic grp_t idx_group(input arch_idx_t idx);
      return grp_t'(idx[AIW-1 -: 2]);
   endfunction

   // physical register count for a given window count
   function automatic int phys_depth(input int nwin);
      return GRP_SIZE + 2 * GRP_SIZE * nwin;
   endfunction

endpackage

// File: rtl/wrf_win_ctrl.sv
module wrf_win_ctrl
   import wrf_pkg::*;
#(
   parameter int NWIN = 8,
   localparam int WW  = $clog2(NWIN),
   localparam int OW  = $clog2(NWIN + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          save_i,
   input  logic          restore_i,
   output logic [WW-1:0] cur_win_o,
   output logic [WW-1:0] prev_win_o,
   output logic          ovf_o,
   output logic          unf_o
);

   logic [WW-1:0] cwp_q;
   logic [WW-1:0] next_win;
   logic [OW-1:0] occ_q;
   logic          stack_full;
   logic          stack_single;
   move_t         move;

   assign stack_full   = (occ_q == OW'(NWIN - 1));
   assign stack_single = (occ_q == OW'(1));

   always_comb begin
      prev_win_o = (cwp_q == '0) ? WW'(NWIN - 1) : cwp_q - WW'(1);
      next_win   = (cwp_q == WW'(NWIN - 1)) ? '0 : cwp_q + WW'(1);
   end

   always_comb begin
      unique case ({save_i, restore_i})
         2'b10:   move = stack_full   ? MV_OVF : MV_SAVE;
         2'b01:   move = stack_single ? MV_UNF : MV_RESTORE;
         default: move = MV_NONE;
      endcase
   end

   assign ovf_o     = (move == MV_OVF);
   assign unf_o     = (move == MV_UNF);
   assign cur_win_o = cwp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cwp_q <= '0;
         occ_q <= OW'(1);
      end else begin
         unique case (move)
            MV_SAVE: begin
               cwp_q <= prev_win_o;
               occ_q <= occ_q + OW'(1);
            end
            MV_RESTORE: begin
               cwp_q <= next_win;
               occ_q <= occ_q - OW'(1);
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/wrf_idx_map.sv
module wrf_idx_map
   import wrf_pkg::*;
#(
   parameter int NWIN = 8,
   localparam int WW  = $clog2(NWIN),
   localparam int PW  = $clog2(phys_depth(NWIN))
) (
   input  arch_idx_t     idx_i,
   input  logic [WW-1:0] cur_win_i,
   input  logic [WW-1:0] prev_win_i,
   output logic [PW-1:0] phys_o
);

   // Window w occupies 16 slots from 8+16w: locals first, then incoming.
   // Outgoing of w lives in the incoming slots of w-1, so offset bit 3
   // of the architectural index already selects the right half.
   logic [WW-1:0] sel_win;
   logic [PW-1:0] win_base;

   always_comb begin
      sel_win  = (idx_group(idx_i) == GRP_OUT) ? prev_win_i : cur_win_i;
      win_base = PW'(GRP_SIZE) + (PW'(sel_win) << 4);
      if (idx_group(idx_i) == GRP_GLOBAL)
         phys_o = PW'(idx_i[2:0]);
      else
         phys_o = win_base + PW'(idx_i[3:0]);
   end

endmodule

// File: rtl/wrf_store.sv
module wrf_store #(
   parameter int DEPTH = 136,
   parameter int DW    = 32,
   parameter int NRD   = 2,
   localparam int PW   = $clog2(DEPTH)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we_i,
   input  logic [PW-1:0]           waddr_i,
   input  logic [DW-1:0]           wdata_i,
   input  logic [NRD-1:0][PW-1:0]  raddr_i,
   output logic [NRD-1:0][DW-1:0]  rdata_o
);

   logic [DW-1:0] mem_q [DEPTH];
   logic          wr_ok;

   // slot 0 is the hard-wired zero register
   assign wr_ok = we_i && (waddr_i != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (wr_ok) begin
         mem_q[waddr_i] <= wdata_i;
      end
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      assign rdata_o[p] = (raddr_i[p] == '0) ? '0 : mem_q[raddr_i[p]];
   end

endmodule

// File: rtl/wreg_file.sv
module wreg_file
   import wrf_pkg::*;
#(
   parameter int NWIN = 8,
   parameter int DW   = 32,
   localparam int WW  = $clog2(NWIN)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          save_i,
   input  logic          restore_i,
   input  logic          we_i,
   input  logic [4:0]    waddr_i,
   input  logic [DW-1:0] wdata_i,
   input  logic [4:0]    raddr_a_i,
   input  logic [4:0]    raddr_b_i,
   output logic [DW-1:0] rdata_a_o,
   output logic [DW-1:0] rdata_b_o,
   output logic [WW-1:0] cur_win_o,
   output logic          ovf_o,
   output logic          unf_o
);

   localparam int DEPTH = phys_depth(NWIN);
   localparam int PW    = $clog2(DEPTH);
   localparam int NRD   = 2;

   if (NWIN < 2 || NWIN > 32) begin : g_bad_nwin
      $error("wreg_file: NWIN must lie in 2..32");
   end
   if (DW < 1) begin : g_bad_dw
      $error("wreg_file: DW must be positive");
   end

   logic [WW-1:0]            prev_win;
   logic [PW-1:0]            wphys;
   arch_idx_t [NRD-1:0]      ridx;
   logic [NRD-1:0][PW-1:0]   rphys;
   logic [NRD-1:0][DW-1:0]   rdata;

   assign ridx[0] = raddr_a_i;
   assign ridx[1] = raddr_b_i;

   wrf_win_ctrl #(.NWIN(NWIN)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .save_i     (save_i),
      .restore_i  (restore_i),
      .cur_win_o  (cur_win_o),
      .prev_win_o (prev_win),
      .ovf_o      (ovf_o),
      .unf_o      (unf_o)
   );

   // write mapped through the pre-move window
   wrf_idx_map #(.NWIN(NWIN)) u_wmap (
      .idx_i      (waddr_i),
      .cur_win_i  (cur_win_o),
      .prev_win_i (prev_win),
      .phys_o     (wphys)
   );

   for (genvar p = 0; p < NRD; p++) begin : g_rmap
      wrf_idx_map #(.NWIN(NWIN)) u_rmap (
         .idx_i      (ridx[p]),
         .cur_win_i  (cur_win_o),
         .prev_win_i (prev_win),
         .phys_o     (rphys[p])
      );
   end

   wrf_store #(.DEPTH(DEPTH), .DW(DW), .NRD(NRD)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (we_i),
      .waddr_i (wphys),
      .wdata_i (wdata_i),
      .raddr_i (rphys),
      .rdata_o (rdata)
   );

   assign rdata_a_o = rdata[0];
   assign rdata_b_o = rdata[1];

endmodule

// File: rtl/wrf_chk.sv
module wrf_chk #(
   parameter int NWIN = 8,
   parameter int DW   = 32,
   localparam int WW  = $clog2(NWIN)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          save_i,
   input logic          restore_i,
   input logic [4:0]    raddr_a_i,
   input logic [4:0]    raddr_b_i,
   input logic [DW-1:0] rdata_a_o,
   input logic [DW-1:0] rdata_b_o,
   input logic [WW-1:0] cur_win_o,
   input logic          ovf_o,
   input logic          unf_o
);

   assert_zero_a_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (raddr_a_i == 5'd0) |-> (rdata_a_o == '0));

   assert_zero_b_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (raddr_b_i == 5'd0) |-> (rdata_b_o == '0));

   assert_save_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (save_i && !restore_i && !ovf_o) |=>
      (int'(cur_win_o) == (int'($past(cur_win_o)) + NWIN - 1) % NWIN));

   assert_restore_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (restore_i && !save_i && !unf_o) |=>
      (int'(cur_win_o) == (int'($past(cur_win_o)) + 1) % NWIN));

   assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!save_i && !restore_i) |=> $stable(cur_win_o));

   assert_no_overflow_move_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |=> $stable(cur_win_o));

   assert_overflow_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |-> (save_i && !restore_i));

   assert_no_underflow_move_R8: assert property (@(posedge clk) disable iff (!rst_n)
      unf_o |=> $stable(cur_win_o));

   assert_underflow_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      unf_o |-> (restore_i && !save_i));

   assert_cancel_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (save_i && restore_i) |-> (!ovf_o && !unf_o));

   assert_cancel_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (save_i && restore_i) |=> $stable(cur_win_o));

endmodule

bind wreg_file wrf_chk #(.NWIN(NWIN), .DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .save_i    (save_i),
   .restore_i (restore_i),
   .raddr_a_i (raddr_a_i),
   .raddr_b_i (raddr_b_i),
   .rdata_a_o (rdata_a_o),
   .rdata_b_o (rdata_b_o),
   .cur_win_o (cur_win_o),
   .ovf_o     (ovf_o),
   .unf_o     (unf_o)
);

// File: tb/sim_wreg_file.sv
module sim_wreg_file;

   localparam int CLK_PERIOD = 10;
   localparam int NW         = 8;
   localparam int DW         = 32;
   localparam int WW         = $clog2(NW);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          save_i = 1'b0, restore_i = 1'b0, we_i = 1'b0;
   logic [4:0]    waddr_i = '0, raddr_a_i = '0, raddr_b_i = '0;
   logic [DW-1:0] wdata_i = '0;
   logic [DW-1:0] rdata_a_o, rdata_b_o;
   logic [WW-1:0] cur_win_o;
   logic          ovf_o, unf_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // behavioural model: per-window arrays, outgoing resolved to the callee's incoming
   logic [DW-1:0] m_glob [8];
   logic [DW-1:0] m_loc  [NW][8];
   logic [DW-1:0] m_in   [NW][8];
   int            m_win;
   int            m_used;

   always #(CLK_PERIOD/2) clk = ~clk;

   wreg_file #(.NWIN(NW), .DW(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .save_i(save_i), .restore_i(restore_i),
      .we_i(we_i), .waddr_i(waddr_i), .wdata_i(wdata_i),
      .raddr_a_i(raddr_a_i), .raddr_b_i(raddr_b_i),
      .rdata_a_o(rdata_a_o), .rdata_b_o(rdata_b_o),
      .cur_win_o(cur_win_o), .ovf_o(ovf_o), .unf_o(unf_o)
   );

   function automatic logic [DW-1:0] m_read(input int idx);
      if (idx == 0)       return '0;
      else if (idx < 8)   return m_glob[idx];
      else if (idx < 16)  return m_in[(m_win + NW - 1) % NW][idx - 8];
      else if (idx < 24)  return m_loc[m_win][idx - 16];
      else                return m_in[m_win][idx - 24];
   endfunction

   task automatic m_write(input int idx, input logic [DW-1:0] d);
      if (idx == 0)       ;
      else if (idx < 8)   m_glob[idx] = d;
      else if (idx < 16)  m_in[(m_win + NW - 1) % NW][idx - 8] = d;
      else if (idx < 24)  m_loc[m_win][idx - 16] = d;
      else                m_in[m_win][idx - 24] = d;
   endtask

   task automatic check(input string tag, input string what,
                        input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // one clock: drive after the falling edge, compare before the rising edge,
   // then advance the model as the edge does
   task automatic cyc(input string tag, input bit sv, input bit rs,
                      input bit we, input int wa, input logic [DW-1:0] wd,
                      input int ra, input int rb);
      bit eo, eu;
      @(negedge clk);
      save_i = sv; restore_i = rs; we_i = we;
      waddr_i = 5'(wa); wdata_i = wd; raddr_a_i = 5'(ra); raddr_b_i = 5'(rb);
      #1;
      eo = sv && !rs && (m_used == NW - 1);
      eu = rs && !sv && (m_used == 1);
      check(tag, "rdata_a", rdata_a_o, m_read(ra));
      check(tag, "rdata_b", rdata_b_o, m_read(rb));
      check(tag, "cur_win", DW'(cur_win_o), DW'(m_win));
      check(tag, "ovf", DW'(ovf_o), DW'(eo));
      check(tag, "unf", DW'(unf_o), DW'(eu));
      if (we) m_write(wa, wd);
      if (sv && !rs && !eo) begin
         m_win = (m_win + NW - 1) % NW; m_used++;
      end else if (rs && !sv && !eu) begin
         m_win = (m_win + 1) % NW; m_used--;
      end
   endtask

   initial begin
      for (int i = 0; i < 8; i++) m_glob[i] = '0;
      for (int w = 0; w < NW; w++)
         for (int i = 0; i < 8; i++) begin
            m_loc[w][i] = '0; m_in[w][i] = '0;
         end
      m_win = 0; m_used = 1;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R6: reset state
      cyc("R6 reset", 0, 0, 0, 0, '0, 17, 30);

      // R1: write to index 0 is dropped, reads zero on both ports
      cyc("R1 write0", 0, 0, 1, 0, 32'hDEAD_BEEF, 0, 0);
      cyc("R1 read0", 0, 0, 0, 0, '0, 0, 0);

      // R2: globals
      for (int i = 1; i < 8; i++)
         cyc("R2 gwrite", 0, 0, 1, i, 32'h6100_0000 + i, 0, 0);
      for (int i = 1; i < 8; i++)
         cyc("R2 gread", 0, 0, 0, 0, '0, i, 8 - i);

      // outgoing and local in window 0, then save
      cyc("R4 setup", 0, 0, 1, 11, 32'hA0A0_0011, 0, 0);
      cyc("R3 setup", 0, 0, 1, 18, 32'hB0B0_0018, 0, 0);
      cyc("R6 save", 1, 0, 0, 0, '0, 11, 18);
      cyc("R4 shared", 0, 0, 0, 0, '0, 27, 11);
      cyc("R3 private", 0, 0, 0, 0, '0, 18, 3);
      cyc("R2 after save", 0, 0, 0, 0, '0, 5, 7);
      // callee writes its incoming group and a local, then returns
      cyc("R5 setup", 0, 0, 1, 25, 32'hC0C0_0025, 0, 0);
      cyc("R3 callee local", 0, 0, 1, 18, 32'hD0D0_0018, 0, 0);
      cyc("R6 restore", 0, 1, 0, 0, '0, 25, 18);
      cyc("R5 returned", 0, 0, 0, 0, '0, 9, 18);

      // R9: same-cycle read returns old value, new value next cycle
      cyc("R9 old", 0, 0, 1, 20, 32'h9999_0020, 20, 20);
      cyc("R9 new", 0, 0, 0, 0, '0, 20, 0);

      // R10: writes in the cycle of a move use the pre-move window
      cyc("R10 save+write", 1, 0, 1, 13, 32'h1010_0013, 13, 0);
      cyc("R10 check in", 0, 0, 0, 0, '0, 29, 13);
      cyc("R10 restore+write", 0, 1, 1, 30, 32'h1010_0030, 30, 0);
      cyc("R10 check out", 0, 0, 0, 0, '0, 14, 30);

      // R11: both strobes cancel, also at the underflow boundary
      cyc("R11 both", 1, 1, 0, 0, '0, 0, 0);
      cyc("R11 hold", 0, 0, 0, 0, '0, 14, 0);

      // R7: fill to the limit, wrapping the pointer through 0 -> NW-1
      for (int i = 0; i < NW - 2; i++)
         cyc("R6 save wrap", 1, 0, 1, 8 + i, 32'h7000_0000 + i, 0, 0);
      cyc("R7 overflow", 1, 0, 0, 0, '0, 0, 0);
      cyc("R7 hold", 0, 0, 0, 0, '0, 24, 8);
      cyc("R11 both full", 1, 1, 0, 0, '0, 0, 0);

      // R8: drain and underflow, wrapping NW-1 -> 0
      for (int i = 0; i < NW - 2; i++)
         cyc("R6 restore wrap", 0, 1, 0, 0, '0, 24 + i, 8 + i);
      cyc("R8 underflow", 0, 1, 0, 0, '0, 0, 0);
      cyc("R8 hold", 0, 0, 0, 0, '0, 8, 15);

      // R12: mixed traffic with independent read indices
      for (int n = 0; n < 600; n++) begin
         int r;
         r = int'($urandom_range(0, 9));
         cyc("R12 mix", r == 0 || r == 9, r == 1 || r == 9,
             $urandom_range(0, 1) == 1, int'($urandom_range(0, 31)),
             $urandom, int'($urandom_range(0, 31)), int'($urandom_range(0, 31)));
      end
      cyc("R12 final", 0, 0, 0, 0, '0, 31, 16);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule